// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key-Code Queue

This block watches a matrix of 64 keys arranged as eight rows by eight columns. A free-running counter steps an encoded row number out to the matrix, and for each row the block samples eight column return lines. A key press is accepted only after it has been seen on two scan passes in a row. It is then turned into a one-byte key code that also holds the levels of a shift input and a control input, and pushed into an eight-entry first-in first-out queue.

A processor reaches the block over a simple strobed bus with one address bit. With the address bit low, a read pops the oldest key code. With the address bit high, a read returns a status byte and a write is a command. The command chooses between two arbitration policies for keys held down together. In lockout, a single key is taken and the rest are ignored. In rollover, every key is taken in turn. An interrupt request stays high as long as the queue holds anything. The time spent on each row is a parameter.

Top module: `keymatrix_scanner`

## Requirements
- R1: `scan_row` starts at 0 after reset, advances by one after every SCAN_DIV clock cycles and wraps from 7 to 0. The column inputs are sampled in the last cycle of each row period.
- R2: A key is accepted only after it has been sampled closed on two consecutive scans of its row. A closure seen on a single scan is never queued.
- R3: A queued key code carries the control level in bit 7, the shift level in bit 6, the row in bits 5:3 and the column in bits 2:0. Both levels are taken in the cycle of acceptance.
- R4: Data reads (addr=0) return key codes in the order they were accepted. A read data byte appears on `rdata` in the cycle after the read strobe.
- R5: `irq` is high whenever the queue holds at least one code, and goes low after the read that removes the last one.
- R6: In lockout mode, while any accepted key is still closed, no other key is accepted. Among several keys eligible in the same row, the lowest column is taken.
- R7: In rollover mode, every key held down is accepted and queued on its own. Each row accepts at most one key per scan pass, lowest column first.
- R8: A command write (addr=1) with bit 0 = 1 selects rollover, and with bit 0 = 0 selects lockout. Reset selects lockout.
- R9: A status read (addr=1) returns the queue entry count in bits 3:0 and the overrun flag in bit 4. Bits 7:5 are zero.
- R10: A key accepted while the queue holds 8 codes is dropped and sets the overrun flag. The flag is cleared by a status read.
- R11: A data read from an empty queue returns 0x00 and leaves the count unchanged.
- R12: A write with addr=0 has no effect on the arbitration mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| col_in | input | 8 | Column return lines for the row being scanned, 1 = key closed |
| shift_in | input | 1 | Shift level stored with each key |
| ctrl_in | input | 1 | Control level stored with each key |
| scan_row | output | 3 | Encoded row currently driven onto the matrix |
| cs | input | 1 | Bus select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 1 | 0 selects key data, 1 selects status or command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt request, high while the queue is not empty |

## Verification
The hardest situation to reach from the ports is a queue overrun. It needs nine separate acceptances with no read in between. Each row grants at most one key per pass, so the bench holds down a full row plus one key in the next row and waits enough passes for all of them to trickle in. The predicted order interleaves the two rows, and the last column of the full row is the code that gets dropped. Lockout against rollover is checked with simultaneous presses timed from the observed `scan_row`, so that the order of first detection is known in advance.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int KMS_ROWS  = 8;
  localparam int KMS_COLS  = 8;
  localparam int ROW_W     = $clog2(KMS_ROWS);
  localparam int COL_W     = $clog2(KMS_COLS);
  localparam int Q_DEPTH   = 8;
  localparam int Q_PTR_W   = $clog2(Q_DEPTH);
  localparam int Q_CNT_W   = $clog2(Q_DEPTH + 1);
  localparam int CODE_W    = 2 + ROW_W + COL_W;

  typedef struct packed {
    logic             ctrl;
    logic             shift;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } keycode_t;

  function automatic keycode_t pack_code(input logic ctrl, input logic shift,
                                         input logic [ROW_W-1:0] row,
                                         input logic [COL_W-1:0] col);
    keycode_t k;
    k.ctrl  = ctrl;
    k.shift = shift;
    k.row   = row;
    k.col   = col;
    return k;
  endfunction

  // lowest set bit index; 0 when none set
  function automatic logic [COL_W-1:0] first_set(input logic [KMS_COLS-1:0] v);
    logic [COL_W-1:0] idx;
    idx = '0;
    for (int i = KMS_COLS - 1; i >= 0; i--) begin
      if (v[i]) idx = COL_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [KMS_COLS-1:0] col_onehot(input logic [COL_W-1:0] c);
    return KMS_COLS'(1) << c;
  endfunction

  function automatic logic [ROW_W-1:0] row_after(input logic [ROW_W-1:0] r);
    return (r == ROW_W'(KMS_ROWS - 1)) ? '0 : r + ROW_W'(1);
  endfunction

  function automatic logic [7:0] status_byte(input logic ovf, input logic [Q_CNT_W-1:0] cnt);
    return {3'b000, ovf, 4'(cnt)};
  endfunction
endpackage

// File: rtl/kms_scan_timer.sv
module kms_scan_timer
  import kms_pkg::*;
#(
  parameter int SCAN_DIV = 256
) (
  input  logic             clk,
  input  logic             rst,
  output logic [ROW_W-1:0] row,
  output logic             tick
);
  localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [ROW_W-1:0] row_q;

  assign tick = (div_q == DIV_W'(SCAN_DIV - 1));
  assign row  = row_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      div_q <= '0;
      row_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      row_q <= row_after(row_q);
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/kms_key_tracker.sv
module kms_key_tracker
  import kms_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [ROW_W-1:0]    row,
  input  logic [KMS_COLS-1:0] cols,
  input  logic                rollover,
  output logic                accept,
  output logic [COL_W-1:0]    accept_col,
  output logic                held_any
);
  logic [KMS_COLS-1:0] seen_q [KMS_ROWS];
  logic [KMS_COLS-1:0] held_q [KMS_ROWS];
  logic [KMS_ROWS-1:0] row_busy;
  logic [KMS_COLS-1:0] cand;

  for (genvar r = 0; r < KMS_ROWS; r++) begin : g_busy
    assign row_busy[r] = |held_q[r];
  end
  assign held_any = |row_busy;

  assign cand       = cols & seen_q[row] & ~held_q[row];
  assign accept_col = first_set(cand);
  assign accept     = tick && (|cand) && (rollover || !held_any);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int r = 0; r < KMS_ROWS; r++) begin
        seen_q[r] <= '0;
        held_q[r] <= '0;
      end
    end else if (tick) begin
      seen_q[row] <= cols;
      held_q[row] <= (held_q[row] & cols) |
                     (accept ? col_onehot(accept_col) : '0);
    end
  end
endmodule

// File: rtl/kms_fifo.sv
module kms_fifo
  import kms_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               push_req,
  input  logic [CODE_W-1:0]  push_data,
  input  logic               pop_req,
  output logic [CODE_W-1:0]  head,
  output logic [Q_CNT_W-1:0] count,
  output logic               pushed,
  output logic               popped,
  output logic               dropped
);
  logic [CODE_W-1:0]  mem_q [Q_DEPTH];
  logic [Q_PTR_W-1:0] wr_q, rd_q;
  logic [Q_CNT_W-1:0] cnt_q;
  logic               full;

  assign full    = (cnt_q == Q_CNT_W'(Q_DEPTH));
  assign pushed  = push_req && !full;
  assign dropped = push_req && full;
  assign popped  = pop_req && (cnt_q != '0);
  assign head    = mem_q[rd_q];
  assign count   = cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < Q_DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (pushed) begin
        mem_q[wr_q] <= push_data;
        wr_q        <= wr_q + Q_PTR_W'(1);
      end
      if (popped) rd_q <= rd_q + Q_PTR_W'(1);
      case ({pushed, popped})
        2'b10:   cnt_q <= cnt_q + Q_CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - Q_CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/kms_host_port.sv
module kms_host_port
  import kms_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs,
  input  logic               rd,
  input  logic               wr,
  input  logic               addr,
  input  logic [7:0]         wdata,
  input  logic [CODE_W-1:0]  head,
  input  logic [Q_CNT_W-1:0] count,
  input  logic               dropped,
  output logic               pop_req,
  output logic               rollover,
  output logic               ovf,
  output logic [7:0]         rdata
);
  logic rd_hit, wr_hit;
  logic mode_q, ovf_q;
  logic [7:0] rdata_q;

  assign rd_hit   = cs && rd;
  assign wr_hit   = cs && wr;
  assign pop_req  = rd_hit && !addr;
  assign rollover = mode_q;
  assign ovf      = ovf_q;
  assign rdata    = rdata_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mode_q  <= 1'b0;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (rd_hit) begin
        if (addr)              rdata_q <= status_byte(ovf_q, count);
        else if (count != '0)  rdata_q <= 8'(head);
        else                   rdata_q <= '0;
      end
      if (wr_hit && addr) mode_q <= wdata[0];
      if (dropped)                 ovf_q <= 1'b1;
      else if (rd_hit && addr)     ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kms_pkg::*;
#(
  parameter int SCAN_DIV = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] col_in,
  input  logic       shift_in,
  input  logic       ctrl_in,
  output logic [2:0] scan_row,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  // named internal events, also watched by the checker
  logic               scan_tick;
  logic [ROW_W-1:0]   row_now;
  logic               key_accept;
  logic [COL_W-1:0]   key_col;
  logic               keys_held;
  logic               mode_rollover;
  logic               pop_req;
  logic               q_pushed, q_popped, q_dropped;
  logic [Q_CNT_W-1:0] q_count;
  logic [CODE_W-1:0]  q_head;
  logic               ovf_flag;
  keycode_t           new_code;

  kms_scan_timer #(.SCAN_DIV(SCAN_DIV)) u_timer (
    .clk (clk), .rst (rst), .row (row_now), .tick (scan_tick)
  );

  kms_key_tracker u_track (
    .clk (clk), .rst (rst), .tick (scan_tick), .row (row_now),
    .cols (col_in), .rollover (mode_rollover),
    .accept (key_accept), .accept_col (key_col), .held_any (keys_held)
  );

  assign new_code = pack_code(ctrl_in, shift_in, row_now, key_col);

  kms_fifo u_fifo (
    .clk (clk), .rst (rst), .push_req (key_accept), .push_data (new_code),
    .pop_req (pop_req), .head (q_head), .count (q_count),
    .pushed (q_pushed), .popped (q_popped), .dropped (q_dropped)
  );

  kms_host_port u_host (
    .clk (clk), .rst (rst), .cs (cs), .rd (rd), .wr (wr), .addr (addr),
    .wdata (wdata), .head (q_head), .count (q_count), .dropped (q_dropped),
    .pop_req (pop_req), .rollover (mode_rollover), .ovf (ovf_flag),
    .rdata (rdata)
  );

  assign scan_row = row_now;
  assign irq      = (q_count != '0);
endmodule

// File: rtl/keymatrix_scanner_chk.sv
module keymatrix_scanner_chk
  import kms_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [2:0]         scan_row,
  input logic               irq,
  input logic               scan_tick,
  input logic               key_accept,
  input logic               keys_held,
  input logic               q_pushed,
  input logic               q_popped,
  input logic               q_dropped,
  input logic [Q_CNT_W-1:0] q_count,
  input logic               ovf_flag
);
  assert_scan_step_R1: assert property (@(posedge clk) disable iff (rst)
    scan_tick |=> scan_row == row_after($past(scan_row)));

  assert_row_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |=> $stable(scan_row));

  assert_accept_marks_held_R6: assert property (@(posedge clk) disable iff (rst)
    key_accept |=> keys_held);

  assert_push_grows_R4: assert property (@(posedge clk) disable iff (rst)
    (q_pushed && !q_popped) |=> q_count == $past(q_count) + Q_CNT_W'(1));

  assert_irq_after_push_R5: assert property (@(posedge clk) disable iff (rst)
    q_pushed |=> irq);

  assert_irq_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (q_popped && !q_pushed && q_count == Q_CNT_W'(1)) |=> !irq);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    q_count <= Q_CNT_W'(Q_DEPTH));

  assert_drop_flags_R10: assert property (@(posedge clk) disable iff (rst)
    q_dropped |=> ovf_flag);
endmodule

bind keymatrix_scanner keymatrix_scanner_chk u_chk (
  .clk (clk), .rst (rst), .scan_row (scan_row), .irq (irq),
  .scan_tick (scan_tick), .key_accept (key_accept), .keys_held (keys_held),
  .q_pushed (q_pushed), .q_popped (q_popped), .q_dropped (q_dropped),
  .q_count (q_count), .ovf_flag (ovf_flag)
);

// File: tb/keymatrix_scanner_bench.sv
module keymatrix_scanner_bench;
  localparam int DIV  = 4;
  localparam int PASS = 8 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] col_in;
  logic       shift_in = 1'b0, ctrl_in = 1'b0;
  logic [2:0] scan_row;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  logic [7:0] keys [8];
  logic [7:0] exp_q [$];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign col_in = keys[scan_row];

  keymatrix_scanner #(.SCAN_DIV(DIV)) u_keymatrix_scanner (
    .clk (clk), .rst (rst), .col_in (col_in), .shift_in (shift_in),
    .ctrl_in (ctrl_in), .scan_row (scan_row), .cs (cs), .rd (rd), .wr (wr),
    .addr (addr), .wdata (wdata), .rdata (rdata), .irq (irq)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
    d = rdata;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic wait_passes(input int n);
    repeat (n * PASS) @(negedge clk);
  endtask

  task automatic wait_row(input logic [2:0] r);
    do @(negedge clk); while (scan_row != r);
  endtask

  // driver side: expected code from the R3 layout
  task automatic expect_key(input logic c, input logic s, input int r, input int k);
    exp_q.push_back({c, s, 3'(r), 3'(k)});
  endtask

  task automatic release_all();
    for (int r = 0; r < 8; r++) keys[r] = '0;
  endtask

  // monitor side: read back the queue and compare against expectations
  task automatic drain(input string req);
    logic [7:0] d;
    bus_read(1'b1, d);
    chk({req, " R9 count"}, int'(d[3:0]), exp_q.size());
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      bus_read(1'b0, d);
      chk({req, " R4 order"}, d, e);
    end
    chk({req, " R5 irq low after last read"}, irq, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    release_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 row after reset", scan_row, 0);
    chk("R5 irq after reset", irq, 0);
    bus_read(1'b1, d);
    chk("R9 status after reset", d, 8'h00);

    // R1 dwell per row
    wait_row(3'd2);
    n = 0;
    do begin @(negedge clk); n++; end while (scan_row == 3'd2);
    chk("R1 row dwell", n, DIV);
    chk("R1 next row", scan_row, 3);

    // R11 empty read
    bus_read(1'b0, d);
    chk("R11 empty read data", d, 8'h00);
    bus_read(1'b1, d);
    chk("R11 count unchanged", d, 8'h00);

    // R2 closure seen on one scan only
    wait_row(3'd4);
    keys[4] = 8'h08;
    wait_row(3'd5);
    release_all();
    wait_passes(3);
    bus_read(1'b1, d);
    chk("R2 single-scan closure dropped", d, 8'h00);
    chk("R2 irq stays low", irq, 0);

    // R3 layout, R5 irq, R4 order
    shift_in = 1'b1; ctrl_in = 1'b0;
    keys[3] = 8'h20; expect_key(1'b0, 1'b1, 3, 5);
    wait_passes(3);
    chk("R5 irq with entry", irq, 1);
    release_all(); wait_passes(2);
    shift_in = 1'b0; ctrl_in = 1'b1;
    keys[6] = 8'h04; expect_key(1'b1, 1'b0, 6, 2);
    wait_passes(3);
    release_all(); wait_passes(2);
    ctrl_in = 1'b0;
    drain("R3 code layout");

    // R6 lockout (reset default, R8)
    wait_row(3'd0);
    keys[2] = 8'h02; keys[4] = 8'h80;
    expect_key(1'b0, 1'b0, 2, 1);
    wait_passes(3);
    release_all(); wait_passes(2);
    drain("R6 lockout two rows");

    // R12 data write ignored: still lockout
    bus_write(1'b0, 8'h01);
    wait_row(3'd0);
    keys[5] = 8'h09;
    expect_key(1'b0, 1'b0, 5, 0);
    wait_passes(4);
    release_all(); wait_passes(2);
    drain("R12 data write ignored");

    // R8 + R7 rollover
    bus_write(1'b1, 8'h01);
    wait_row(3'd0);
    keys[1] = 8'h14; keys[6] = 8'h01;
    expect_key(1'b0, 1'b0, 1, 2);
    expect_key(1'b0, 1'b0, 6, 0);
    expect_key(1'b0, 1'b0, 1, 4);
    wait_passes(4);
    release_all(); wait_passes(2);
    drain("R7 rollover");

    // R10 overrun
    wait_row(3'd0);
    keys[1] = 8'hFF; keys[2] = 8'h01;
    wait_passes(11);
    bus_read(1'b1, d);
    chk("R10 status full with overrun", d, 8'h18);
    bus_read(1'b1, d);
    chk("R10 overrun cleared by status read", d, 8'h08);
    release_all(); wait_passes(2);
    expect_key(1'b0, 1'b0, 1, 0);
    expect_key(1'b0, 1'b0, 2, 0);
    for (int k = 1; k < 7; k++) expect_key(1'b0, 1'b0, 1, k);
    drain("R10 kept entries");

    // R8 back to lockout
    bus_write(1'b1, 8'h00);
    wait_row(3'd0);
    keys[7] = 8'h41;
    expect_key(1'b0, 1'b0, 7, 0);
    wait_passes(4);
    release_all(); wait_passes(2);
    drain("R8 lockout restored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule